// File: doc/BRIEF.md
# Streaming Test Pattern Generator

This block supplies test words to a stream so that a link or a memory path can be checked. It makes one of three kinds of data: a maximal-length pseudo-random sequence from a linear feedback shift register, a counter that steps by one and wraps at a programmable modulus, or a fixed word. A request input sets the pace. It is tied to the downstream ready when the generator drives the stream alone, or to an upstream valid when the generator fills another source's beats. One word is produced for each cycle in which the block is enabled and the request is high.

While the enable is low the generator is parked. Its sequence state is reloaded from the 32-bit start value, so the first word after enable is always predictable. A 32-bit transmit counter reports how many words have gone out since the last enable. A parameter sets the output path. With no register the word appears in the same cycle as the request. With a register it appears one cycle later and is held until the next word.

Top module: `test_seq_gen`

## Requirements
- R1: While enable is low, valid stays low, and at each clock edge the counter state is loaded with the start value and the shift-register state with the seed.
- R2: Valid is high only for a request cycle with enable high. With LATENCY=0 it is high in that same cycle. With LATENCY=1 it is high in the following cycle.
- R3: With select low the data is the shift-register state. Each accepted request steps it as next = (state << 1) | parity(state & TAPS). For an 8-bit width TAPS is 0xB8, which gives a period of 2^8-1 = 255 words. The first word after enable is the seed.
- R4: The seed is the start value. A start value of zero is replaced by the value 1, so the register state is never zero.
- R5: With select high the data is the counter. The first word after enable is the start value, and each accepted request adds exactly one.
- R6: With a nonzero modulus M, a step from any value v with v+1 >= M gives 0. With M equal to zero the counter wraps naturally from 2^W-1 to 0.
- R7: With constant mode high, every valid word equals the start value, whatever select is.
- R8: The transmit count rises by one for each accepted request. In the first enabled cycle it restarts at 1 if a request is present and at 0 otherwise. It holds its value while enable is low, and it resets to 0.
- R9: With LATENCY=1 the data output keeps the last valid word in the cycles where valid is low.
- R10: The start value and modulus are taken from the low W bits of their 32-bit inputs when W < 32, and zero-extended when W > 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run the sequence; low parks the generator and reloads it |
| sel_i | input | 1 | 0: pseudo-random data, 1: counter data |
| const_i | input | 1 | Emit the start value as a fixed word |
| init_i | input | 32 | Start value, seed and constant word |
| mod_i | input | 32 | Counter modulus, 0 for natural wrap |
| req_i | input | 1 | Request pace (downstream ready or upstream valid) |
| data_o | output | DATA_W | Generated word |
| valid_o | output | 1 | Word valid |
| tx_cnt_o | output | 32 | Words sent since the last enable |

## Verification
The case that needs the most care is the first enabled cycle when a request is also present. In that one cycle the transmit count must restart and also count the word, and the sequence must emit its seed or start value and step in the same cycle. The bench provokes this with directed re-enables made right after a disabled spell, and with random enable toggling while requests are dense. A reference model in the bench derives both the expected count and the expected word from the requirements, and each is compared at the output where it appears for both latency settings.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    localparam int unsigned CFG_W = 32;
    localparam int unsigned TXC_W = 32;

    typedef enum logic [1:0] {
        SRC_LFSR  = 2'd0,
        SRC_CNT   = 2'd1,
        SRC_CONST = 2'd2
    } src_e;

    // Build a feedback mask from up to four 1-based tap positions (0 = unused).
    function automatic logic [63:0] tap_bits(input int unsigned a, input int unsigned b,
                                             input int unsigned c, input int unsigned d);
        logic [63:0] m;
        m = '0;
        if (a > 0) m[a-1] = 1'b1;
        if (b > 0) m[b-1] = 1'b1;
        if (c > 0) m[c-1] = 1'b1;
        if (d > 0) m[d-1] = 1'b1;
        return m;
    endfunction

    // Maximal-length tap sets for a shift-left register with parity feedback.
    function automatic logic [63:0] lfsr_taps(input int unsigned w);
        case (w)
            2:  return tap_bits(2, 1, 0, 0);
            3:  return tap_bits(3, 2, 0, 0);
            4:  return tap_bits(4, 3, 0, 0);
            5:  return tap_bits(5, 3, 0, 0);
            6:  return tap_bits(6, 5, 0, 0);
            7:  return tap_bits(7, 6, 0, 0);
            8:  return tap_bits(8, 6, 5, 4);
            9:  return tap_bits(9, 5, 0, 0);
            10: return tap_bits(10, 7, 0, 0);
            11: return tap_bits(11, 9, 0, 0);
            12: return tap_bits(12, 6, 4, 1);
            13: return tap_bits(13, 4, 3, 1);
            14: return tap_bits(14, 5, 3, 1);
            15: return tap_bits(15, 14, 0, 0);
            16: return tap_bits(16, 15, 13, 4);
            17: return tap_bits(17, 14, 0, 0);
            18: return tap_bits(18, 11, 0, 0);
            19: return tap_bits(19, 6, 2, 1);
            20: return tap_bits(20, 17, 0, 0);
            21: return tap_bits(21, 19, 0, 0);
            22: return tap_bits(22, 21, 0, 0);
            23: return tap_bits(23, 18, 0, 0);
            24: return tap_bits(24, 23, 22, 17);
            25: return tap_bits(25, 22, 0, 0);
            26: return tap_bits(26, 6, 2, 1);
            27: return tap_bits(27, 5, 2, 1);
            28: return tap_bits(28, 25, 0, 0);
            29: return tap_bits(29, 27, 0, 0);
            30: return tap_bits(30, 6, 4, 1);
            31: return tap_bits(31, 28, 0, 0);
            32: return tap_bits(32, 22, 2, 1);
            default: return (w > 64) ? tap_bits(64, 63, 61, 60)
                                     : tap_bits(w, (w > 1) ? w - 1 : 0, 0, 0);
        endcase
    endfunction

    function automatic src_e pick_src(input logic sel, input logic cst);
        if (cst)      return SRC_CONST;
        else if (sel) return SRC_CNT;
        else          return SRC_LFSR;
    endfunction

endpackage

// File: rtl/tsg_lfsr.sv
module tsg_lfsr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] start_i,
    output logic [W-1:0] state_o
);
    localparam logic [W-1:0] MASK = W'(tsg_pkg::lfsr_taps(W));
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] state_q;
    logic [W-1:0] seed;
    logic [W-1:0] nxt;
    logic         fb;

    always_comb begin
        seed = (start_i == '0) ? ONE : start_i;
        fb   = ^(state_q & MASK);
        nxt  = (state_q << 1) | W'(fb);
    end

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            state_q <= seed;
        end else if (step_i) begin
            state_q <= nxt;
        end
    end

    assign state_o = state_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0); // R4

endmodule

// File: rtl/tsg_mod_counter.sv
module tsg_mod_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;
    logic [W:0]   inc;
    logic         wrap;
    logic [W-1:0] nxt;

    always_comb begin
        inc  = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
        wrap = (mod_i != '0) && (inc >= {1'b0, mod_i});
        nxt  = wrap ? '0 : inc[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            cnt_q <= start_i;
        end else if (step_i) begin
            cnt_q <= nxt;
        end
    end

    assign cnt_o = cnt_q;

    AST_CNT_BELOW_MOD: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && mod_i != '0 && cnt_q < mod_i) |=> (cnt_q < $past(mod_i))); // R6

    AST_CNT_PARKED: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(start_i))); // R1

endmodule

// File: rtl/tsg_tx_counter.sv
module tsg_tx_counter #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          step_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_q;
    logic          en_q;
    logic          first;

    assign first = en_i && !en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else begin
            en_q <= en_i;
            if (first) begin
                cnt_q <= CW'(step_i);
            end else if (step_i) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign cnt_o = cnt_q;

    AST_TX_INC: assert property (@(posedge clk) disable iff (rst)
        (en_i && en_q && step_i) |=> (cnt_o == $past(cnt_o) + CW'(1))); // R8

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(cnt_o)); // R8

endmodule

// File: rtl/tsg_out_stage.sv
module tsg_out_stage #(
    parameter int unsigned W       = 16,
    parameter int unsigned LATENCY = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] dat_i,
    output logic         vld_o,
    output logic [W-1:0] dat_o
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } beat_t;

    beat_t beat_in;
    beat_t beat_out;

    assign beat_in = '{vld: vld_i, dat: dat_i};

    generate
        if (LATENCY == 0) begin : g_comb
            assign beat_out = beat_in;
        end else begin : g_reg
            beat_t beat_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    beat_q <= '0;
                end else begin
                    beat_q.vld <= beat_in.vld;
                    if (beat_in.vld) begin
                        beat_q.dat <= beat_in.dat;
                    end
                end
            end
            assign beat_out = beat_q;

            AST_DAT_HOLD: assert property (@(posedge clk) disable iff (rst)
                !vld_i |=> $stable(dat_o)); // R9
        end
    endgenerate

    assign vld_o = beat_out.vld;
    assign dat_o = beat_out.dat;

endmodule

// File: rtl/test_seq_gen.sv
module test_seq_gen
    import tsg_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned LATENCY = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              sel_i,
    input  logic              const_i,
    input  logic [CFG_W-1:0]  init_i,
    input  logic [CFG_W-1:0]  mod_i,
    input  logic              req_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic [TXC_W-1:0]  tx_cnt_o
);
    logic [DATA_W-1:0] start_w;
    logic [DATA_W-1:0] mod_w;
    logic [DATA_W-1:0] lfsr_v;
    logic [DATA_W-1:0] cnt_v;
    logic [DATA_W-1:0] word;
    logic              load;
    logic              step;
    src_e              src;

    // 32-bit settings resized to the data width (truncate or zero-extend)
    assign start_w = DATA_W'(init_i);
    assign mod_w   = DATA_W'(mod_i);

    assign load = !en_i;
    assign step = en_i && req_i;

    tsg_lfsr #(.W(DATA_W)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .step_i  (step),
        .start_i (start_w),
        .state_o (lfsr_v)
    );

    tsg_mod_counter #(.W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .step_i  (step),
        .start_i (start_w),
        .mod_i   (mod_w),
        .cnt_o   (cnt_v)
    );

    tsg_tx_counter #(.CW(TXC_W)) u_txc (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .step_i (step),
        .cnt_o  (tx_cnt_o)
    );

    always_comb begin
        src = pick_src(sel_i, const_i);
        unique case (src)
            SRC_CONST: word = start_w;
            SRC_CNT:   word = cnt_v;
            default:   word = lfsr_v;
        endcase
    end

    tsg_out_stage #(.W(DATA_W), .LATENCY(LATENCY)) u_out (
        .clk   (clk),
        .rst   (rst),
        .vld_i (step),
        .dat_i (word),
        .vld_o (valid_o),
        .dat_o (data_o)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !$past(en_i)) |-> !valid_o); // R1

    generate
        if (LATENCY == 0) begin : g_chk0
            AST_VAL_ON_REQ: assert property (@(posedge clk) disable iff (rst)
                valid_o |-> (req_i && en_i)); // R2
            AST_CONST_WORD: assert property (@(posedge clk) disable iff (rst)
                (valid_o && const_i) |-> (data_o == start_w)); // R7
        end else begin : g_chk1
            AST_VAL_ON_REQ: assert property (@(posedge clk) disable iff (rst)
                valid_o |-> $past(req_i && en_i)); // R2
            AST_CONST_WORD: assert property (@(posedge clk) disable iff (rst)
                (valid_o && $past(const_i)) |-> (data_o == $past(start_w))); // R7
        end
    endgenerate

endmodule

// File: tb/test_seq_gen_tb_top.sv
module test_seq_gen_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0, sel = 1'b0, cst = 1'b0, rq = 1'b0;
    logic [31:0]  init_r = '0, mod_r = '0;
    logic [W-1:0] d1, d0;
    logic         v1, v0;
    logic [31:0]  t1, t0;

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [W-1:0] m_lfsr, m_cnt, last1, last0;
    logic [31:0]  m_tx;
    bit           m_en_prev;

    always #5 clk = ~clk;

    test_seq_gen #(.DATA_W(W), .LATENCY(1)) dut_i (
        .clk(clk), .rst(rst), .en_i(en), .sel_i(sel), .const_i(cst),
        .init_i(init_r), .mod_i(mod_r), .req_i(rq),
        .data_o(d1), .valid_o(v1), .tx_cnt_o(t1));

    test_seq_gen #(.DATA_W(W), .LATENCY(0)) dut_l0_i (
        .clk(clk), .rst(rst), .en_i(en), .sel_i(sel), .const_i(cst),
        .init_i(init_r), .mod_i(mod_r), .req_i(rq),
        .data_o(d0), .valid_o(v0), .tx_cnt_o(t0));

    function automatic logic [W-1:0] f_seed(input logic [W-1:0] s);
        return (s == '0) ? W'(1) : s;
    endfunction

    function automatic logic [W-1:0] f_lfsr(input logic [W-1:0] s);
        return {s[W-2:0], ^(s & 8'hB8)};
    endfunction

    function automatic logic [W-1:0] f_cnt(input logic [W-1:0] c, input logic [W-1:0] m);
        logic [W:0] inc;
        inc = {1'b0, c} + 1;
        if (m != '0 && inc >= {1'b0, m}) return '0;
        return inc[W-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // one clock cycle with the given inputs; tag names the requirement on data
    task automatic cyc(input bit e, input bit s, input bit c, input bit r, input string tag);
        logic [W-1:0] start_w, mod_w, exp;
        bit vexp;
        @(negedge clk);
        en = e; sel = s; cst = c; rq = r;
        start_w = init_r[W-1:0];
        mod_w   = mod_r[W-1:0];
        exp  = c ? start_w : (s ? m_cnt : m_lfsr);
        vexp = e && r;
        #1;
        check(v0 == vexp, e ? "R2" : "R1", "valid lat0", 32'(v0), 32'(vexp));
        if (vexp) check(d0 == exp, tag, "data lat0", 32'(d0), 32'(exp));
        last0 = d0;
        // model update for the coming edge
        if (!e) begin
            m_lfsr = f_seed(start_w);
            m_cnt  = start_w;
        end else if (r) begin
            m_lfsr = f_lfsr(m_lfsr);
            m_cnt  = f_cnt(m_cnt, mod_w);
        end
        if (e && !m_en_prev) m_tx = 32'(r);
        else if (e && r)     m_tx = m_tx + 1;
        m_en_prev = e;
        if (vexp) last1 = exp;
        @(posedge clk);
        #1;
        check(v1 == vexp, e ? "R2" : "R1", "valid lat1", 32'(v1), 32'(vexp));
        check(d1 == last1, vexp ? tag : "R9", "data lat1", 32'(d1), 32'(last1));
        check(t1 == m_tx && t0 == m_tx, "R8", "tx count", t1, m_tx);
    endtask

    initial begin
        #1_900_000;
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int first_dat, period, dummy;
        dummy = $urandom(32'd1234);
        m_lfsr = W'(1); m_cnt = '0; m_tx = '0; m_en_prev = 0; last1 = '0; last0 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // reset state
        check(v1 == 1'b0 && v0 == 1'b0, "R1", "reset valid", 32'(v1), 0);
        check(t1 == 0 && t0 == 0, "R8", "reset tx count", t1, 0);
        check(d1 == '0, "R9", "reset data", 32'(d1), 0);

        // counter, start 3, modulus 5, random request gaps
        init_r = 32'd3; mod_r = 32'd5;
        repeat (2) cyc(0, 1, 0, 1, "R1");
        for (int i = 0; i < 40; i++) cyc(1, 1, 0, ($urandom % 3) != 0, "R6");
        check(m_cnt < 5, "R6", "model below modulus", 32'(m_cnt), 5);

        // natural wrap with modulus 0
        init_r = 32'd250; mod_r = 32'd0;
        cyc(0, 1, 0, 0, "R1");
        for (int i = 0; i < 12; i++) cyc(1, 1, 0, 1, "R6");

        // start value above modulus jumps to zero
        init_r = 32'd9; mod_r = 32'd5;
        cyc(0, 1, 0, 1, "R1");
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 1, "R5");

        // LFSR with zero start value: seed 1, full period
        init_r = 32'd0; mod_r = 32'd0;
        repeat (2) cyc(0, 0, 0, 1, "R1");
        cyc(1, 0, 0, 1, "R4");
        first_dat = int'(last0);
        check(first_dat == 1, "R4", "seed replaces zero", 32'(first_dat), 1);
        period = 0;
        for (int i = 1; i <= 256; i++) begin
            cyc(1, 0, 0, 1, "R3");
            if (period == 0 && int'(last0) == first_dat) period = i;
        end
        check(period == 255, "R3", "lfsr period", 32'(period), 255);

        // nonzero seed with gaps
        init_r = 32'h5A;
        cyc(0, 0, 0, 0, "R1");
        for (int i = 0; i < 30; i++) cyc(1, 0, 0, ($urandom % 2) == 0, "R3");

        // constant mode with both selects
        init_r = 32'hC3;
        for (int i = 0; i < 30; i++) cyc(1, ($urandom % 2) == 1, 1, ($urandom % 3) != 0, "R7");

        // count held while disabled, restarts on enable with request
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, "R1");
        cyc(1, 1, 0, 1, "R8");
        cyc(1, 1, 0, 1, "R8");
        cyc(0, 1, 0, 0, "R1");
        cyc(1, 1, 0, 0, "R8");

        // truncation of 32-bit settings
        init_r = 32'h1F3; mod_r = 32'h1F6;
        cyc(0, 1, 0, 0, "R1");
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, 1, "R10");

        // random mix
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 40) == 0) init_r = $urandom;
            if (($urandom % 40) == 0) begin
                case ($urandom % 4)
                    0: mod_r = 32'd0;
                    1: mod_r = 32'd3;
                    2: mod_r = 32'd5;
                    default: mod_r = 32'd200;
                endcase
            end
            cyc(($urandom % 8) != 0, ($urandom % 2) == 1, ($urandom % 6) == 0,
                ($urandom % 3) != 0, "R5");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule